// File: doc/BRIEF.md
# Reed-Solomon Block Framing and Setup Controller

This block sits at the front of a programmable byte-symbol Reed-Solomon decoder. It handles the decoder's setup and framing. The Galois-field arithmetic is not part of it. Setup has two phases, and both are driven only by an active-low init strobe and a data-enable strobe. In the first phase, init and data-enable are both held low for a while. During that time the block latches the flag threshold, the status-enable option and the latency mode. After init goes high, the block waits for a training block. It counts how many symbols data-enable stays high, which gives the data count k. It counts how many symbols data-enable then stays low, which gives the parity count r. The block length is N = k + r.

When the next rising edge of data-enable arrives, the learned geometry is frozen. From that symbol onward the block frames the stream on its own and ignores data-enable. For every symbol it outputs a valid strobe, an index within the block, a parity flag and a block-start pulse. It also checks the learned geometry against the legal parity range, the largest block length, and a minimum length set by the latency mode. If any check fails, it raises a configuration error and keeps the framing outputs quiet.

Top module: `rs_frame_setup`

## Requirements
- R1: On every clock edge where initN is low, thrHeld takes thrIn and statusOn takes statusReq. While initN stays high, both hold their value whatever the inputs do.
- R2: Setup is armed only if initN and dataEn were both low for at least 4 consecutive edges before initN rises. Otherwise no training takes place, setupDone stays 0 and symValid stays 0 until the next init cycle.
- R3: Training begins with the first rising edge of dataEn that comes after at least two edges with initN high. k is the number of high symbols and r is the number of low symbols that follow. On the next rising edge, learnedN = k+r, learnedR = r and setupDone = 1. All three appear one clock after that edge is sampled.
- R4: Symbols of the training block are never marked valid, and symValid stays 0 while setupDone is 0.
- R5: After training, and with no error, each sampled symbol appears one clock later on symOut with symValid high. symIdx runs 0..N-1 and then wraps to 0. blockStart is high exactly when symIdx is 0. The first symbol after the training block has index 0.
- R6: isParity is 1 for indices N-r..N-1 and 0 for indices 0..N-r-1.
- R7: After training, framing depends only on the learned N and r. Any later dataEn activity has no effect.
- R8: configError is set if r < 8 or r > 20.
- R9: configError is set if N > 255. N = 255 is legal.
- R10: latMode selects the minimum block length. 00 gives 5r+15, 01 gives 2r+13, and 1x gives floor(3r/2)+15. configError is set when N is below that minimum, and N equal to the minimum is legal.
- R11: While configError is 1, symValid and blockStart stay 0.
- R12: latMode is latched only while initN is low. Changes to it after initN rises do not affect the length check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| initN | input | 1 | Active-low init strobe; low starts setup phase one |
| dataEn | input | 1 | High for data symbols, low for parity symbols |
| symIn | input | 8 | Incoming symbol |
| thrIn | input | 5 | Uncorrectable-flag threshold bus |
| statusReq | input | 1 | Status-byte output option |
| latMode | input | 2 | Latency mode select |
| symOut | output | 8 | Symbol, delayed one clock |
| thrHeld | output | 5 | Latched threshold |
| statusOn | output | 1 | Latched status option |
| learnedN | output | 10 | Learned block length |
| learnedR | output | 9 | Learned parity count |
| setupDone | output | 1 | Training finished |
| symValid | output | 1 | symOut carries a framed symbol |
| isParity | output | 1 | Framed symbol is a parity symbol |
| symIdx | output | 8 | Index of the symbol within its block |
| blockStart | output | 1 | First symbol of a block |
| configError | output | 1 | Learned geometry is illegal for the mode |

## Verification
Every output is registered one stage after the edge that samples the inputs it depends on. Per-symbol framing and symOut are due one clock after the symbol is sampled. The learned N, r, setupDone and configError are due one clock after the edge that samples the rising dataEn closing the training parity span. The latched threshold and status are due one clock after each low-init edge. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It compares every output at the next falling edge, so each expectation is checked exactly in the cycle the design is required to present it.

// File: rtl/rs_frame_pkg.sv
package rs_frame_pkg;

  typedef enum logic [2:0] {
    ST_PRIME, ST_IDLE, ST_ARM, ST_TDATA, ST_TPAR, ST_RUN
  } frameState_t;

  // control -> datapath strobes, one clock edge each
  typedef struct packed {
    logic prime;    // init low: latch options, clear learned state
    logic dataInc;  // training: one more data symbol
    logic parInc;   // training: one more parity symbol
    logic learn;    // training closed: freeze geometry, emit index 0
    logic frame;    // normal framing of one symbol
  } frameStrobe_t;

endpackage

// File: rtl/rs_frame_ctl.sv
module rs_frame_ctl
  import rs_frame_pkg::*;
#(
  parameter int LOW_MIN = 4,
  parameter int ARM_MIN = 2
) (
  input  logic         clk,
  input  logic         initN,
  input  logic         dataEn,
  output frameStrobe_t strb
);
  localparam int LCW = $clog2(LOW_MIN + 1);
  localparam int ACW = $clog2(ARM_MIN + 1);

  frameState_t    state;
  logic [LCW-1:0] lowCnt;
  logic [ACW-1:0] armCnt;
  logic           prevEn;
  logic           armReady;
  logic           enRise;

  assign armReady = (armCnt >= ACW'(ARM_MIN));
  assign enRise   = dataEn && !prevEn;

  always_ff @(posedge clk) begin
    prevEn <= dataEn;
    if (!initN) begin
      state  <= ST_PRIME;
      armCnt <= '0;
      if (dataEn)
        lowCnt <= '0;
      else if (state == ST_PRIME) begin
        if (lowCnt < LCW'(LOW_MIN)) lowCnt <= lowCnt + 1'b1;
      end else
        lowCnt <= LCW'(1);
    end else begin
      case (state)
        ST_PRIME: begin
          state  <= (lowCnt >= LCW'(LOW_MIN)) ? ST_ARM : ST_IDLE;
          armCnt <= ACW'(1);
        end
        ST_ARM: begin
          if (armReady && enRise) state <= ST_TDATA;
          else if (!armReady)     armCnt <= armCnt + 1'b1;
        end
        ST_TDATA: if (!dataEn) state <= ST_TPAR;
        ST_TPAR:  if (dataEn)  state <= ST_RUN;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.prime   = !initN;
    strb.dataInc = initN && ((state == ST_ARM && armReady && enRise) ||
                             (state == ST_TDATA && dataEn));
    strb.parInc  = initN && !dataEn && (state == ST_TDATA || state == ST_TPAR);
    strb.learn   = initN && (state == ST_TPAR) && dataEn;
    strb.frame   = initN && (state == ST_RUN);
  end

endmodule

// File: rtl/rs_frame_dp.sv
module rs_frame_dp
  import rs_frame_pkg::*;
#(
  parameter int MAX_N = 255,
  parameter int R_MIN = 8,
  parameter int R_MAX = 20,
  parameter int PW    = 5,
  parameter int SW    = 8,
  localparam int IW   = $clog2(MAX_N + 1),
  localparam int CW   = IW + 1,
  localparam int LW   = CW + 1
) (
  input  logic          clk,
  input  frameStrobe_t  strb,
  input  logic [SW-1:0] symIn,
  input  logic [PW-1:0] thrIn,
  input  logic          statusReq,
  input  logic [1:0]    latMode,
  output logic [SW-1:0] symOut,
  output logic [PW-1:0] thrHeld,
  output logic          statusOn,
  output logic [LW-1:0] learnedN,
  output logic [CW-1:0] learnedR,
  output logic          setupDone,
  output logic          symValid,
  output logic          isParity,
  output logic [IW-1:0] symIdx,
  output logic          blockStart,
  output logic          configError
);
  localparam int MW = CW + 3;

  logic [CW-1:0] dCnt, pCnt, kHeld;
  logic [1:0]    modeHeld;
  logic [LW-1:0] pos;
  logic [LW-1:0] trainN;
  logic [MW-1:0] rExt, minLen;
  logic          trainErr, lastPos;

  // geometry check on the counts that are about to be frozen
  always_comb begin
    trainN = {1'b0, dCnt} + {1'b0, pCnt};
    rExt   = MW'(pCnt);
    if (modeHeld[1])      minLen = rExt + (rExt >> 1) + MW'(15);
    else if (modeHeld[0]) minLen = (rExt << 1) + MW'(13);
    else                  minLen = (rExt << 2) + rExt + MW'(15);
    trainErr = (pCnt < CW'(R_MIN)) || (pCnt > CW'(R_MAX)) ||
               (trainN > LW'(MAX_N)) || (MW'(trainN) < minLen);
  end

  assign lastPos = (pos == learnedN - LW'(1));

  always_ff @(posedge clk) begin
    symOut <= symIn;
    if (strb.prime) begin
      thrHeld     <= thrIn;
      statusOn    <= statusReq;
      modeHeld    <= latMode;
      dCnt        <= '0;
      pCnt        <= '0;
      kHeld       <= '0;
      learnedN    <= '0;
      learnedR    <= '0;
      setupDone   <= 1'b0;
      configError <= 1'b0;
      symValid    <= 1'b0;
      blockStart  <= 1'b0;
      isParity    <= 1'b0;
      symIdx      <= '0;
      pos         <= '0;
    end else begin
      symValid   <= 1'b0;
      blockStart <= 1'b0;
      if (strb.dataInc && dCnt != '1) dCnt <= dCnt + 1'b1;
      if (strb.parInc && pCnt != '1)  pCnt <= pCnt + 1'b1;
      if (strb.learn) begin
        learnedN    <= trainN;
        learnedR    <= pCnt;
        kHeld       <= dCnt;
        configError <= trainErr;
        setupDone   <= 1'b1;
        symValid    <= !trainErr;
        blockStart  <= !trainErr;
        isParity    <= 1'b0;
        symIdx      <= '0;
        pos         <= LW'(1);
      end
      if (strb.frame) begin
        symValid   <= !configError;
        blockStart <= !configError && (pos == '0);
        isParity   <= (pos >= LW'(kHeld));
        symIdx     <= pos[IW-1:0];
        pos        <= lastPos ? '0 : pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rs_frame_setup.sv
module rs_frame_setup
  import rs_frame_pkg::*;
#(
  parameter int MAX_N = 255,
  parameter int R_MIN = 8,
  parameter int R_MAX = 20,
  parameter int PW    = 5,
  parameter int SW    = 8,
  localparam int IW   = $clog2(MAX_N + 1),
  localparam int CW   = IW + 1,
  localparam int LW   = CW + 1
) (
  input  logic          clk,
  input  logic          initN,
  input  logic          dataEn,
  input  logic [SW-1:0] symIn,
  input  logic [PW-1:0] thrIn,
  input  logic          statusReq,
  input  logic [1:0]    latMode,
  output logic [SW-1:0] symOut,
  output logic [PW-1:0] thrHeld,
  output logic          statusOn,
  output logic [LW-1:0] learnedN,
  output logic [CW-1:0] learnedR,
  output logic          setupDone,
  output logic          symValid,
  output logic          isParity,
  output logic [IW-1:0] symIdx,
  output logic          blockStart,
  output logic          configError
);
  frameStrobe_t strb;

  rs_frame_ctl #(.LOW_MIN(4), .ARM_MIN(2)) ctl_i (
    .clk(clk), .initN(initN), .dataEn(dataEn), .strb(strb)
  );

  rs_frame_dp #(
    .MAX_N(MAX_N), .R_MIN(R_MIN), .R_MAX(R_MAX), .PW(PW), .SW(SW)
  ) dp_i (
    .clk(clk), .strb(strb), .symIn(symIn), .thrIn(thrIn),
    .statusReq(statusReq), .latMode(latMode), .symOut(symOut),
    .thrHeld(thrHeld), .statusOn(statusOn), .learnedN(learnedN),
    .learnedR(learnedR), .setupDone(setupDone), .symValid(symValid),
    .isParity(isParity), .symIdx(symIdx), .blockStart(blockStart),
    .configError(configError)
  );

endmodule

// File: rtl/rs_frame_setup_chk.sv
module rs_frame_setup_chk #(
  parameter int MAX_N = 255,
  parameter int PW    = 5,
  localparam int IW   = $clog2(MAX_N + 1),
  localparam int CW   = IW + 1,
  localparam int LW   = CW + 1
) (
  input logic          clk,
  input logic          initN,
  input logic [PW-1:0] thrHeld,
  input logic          statusOn,
  input logic [LW-1:0] learnedN,
  input logic [CW-1:0] learnedR,
  input logic          setupDone,
  input logic          symValid,
  input logic          isParity,
  input logic [IW-1:0] symIdx,
  input logic          blockStart,
  input logic          configError
);

  a_r1_opts_held: assert property (@(posedge clk) disable iff (!initN)
    $past(initN) |-> ($stable(thrHeld) && $stable(statusOn)));

  a_r3_geometry_frozen: assert property (@(posedge clk) disable iff (!initN)
    $past(setupDone) |-> (setupDone && $stable(learnedN) && $stable(learnedR)));

  a_r4_quiet_before_setup: assert property (@(posedge clk) disable iff (!initN)
    !setupDone |-> !symValid);

  a_r5_start_at_zero: assert property (@(posedge clk) disable iff (!initN)
    blockStart |-> (symValid && symIdx == '0));

  a_r5_index_step: assert property (@(posedge clk) disable iff (!initN)
    (symValid && $past(symValid) && !blockStart) |->
      (LW'(symIdx) == LW'($past(symIdx)) + LW'(1)));

  a_r5_wrap_at_end: assert property (@(posedge clk) disable iff (!initN)
    (blockStart && $past(symValid)) |-> (LW'($past(symIdx)) == learnedN - LW'(1)));

  a_r6_parity_span: assert property (@(posedge clk) disable iff (!initN)
    symValid |-> (isParity == (LW'(symIdx) >= learnedN - LW'(learnedR))));

  a_r11_error_quiet: assert property (@(posedge clk) disable iff (!initN)
    configError |-> (!symValid && !blockStart));

endmodule

bind rs_frame_setup rs_frame_setup_chk #(.MAX_N(MAX_N), .PW(PW)) chk_i (
  .clk(clk), .initN(initN), .thrHeld(thrHeld), .statusOn(statusOn),
  .learnedN(learnedN), .learnedR(learnedR), .setupDone(setupDone),
  .symValid(symValid), .isParity(isParity), .symIdx(symIdx),
  .blockStart(blockStart), .configError(configError)
);

// File: tb/rs_frame_setup_tb_top.sv
module rs_frame_setup_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       initN = 1'b0;
  logic       dataEn = 1'b0;
  logic [7:0] symIn = 8'd0;
  logic [4:0] thrIn = 5'd0;
  logic       statusReq = 1'b0;
  logic [1:0] latMode = 2'd0;
  logic [7:0] symOut;
  logic [4:0] thrHeld;
  logic       statusOn;
  logic [9:0] learnedN;
  logic [8:0] learnedR;
  logic       setupDone, symValid, isParity, blockStart, configError;
  logic [7:0] symIdx;

  always #(CLK_P / 2) clk = ~clk;

  rs_frame_setup dut_i (
    .clk(clk), .initN(initN), .dataEn(dataEn), .symIn(symIn), .thrIn(thrIn),
    .statusReq(statusReq), .latMode(latMode), .symOut(symOut),
    .thrHeld(thrHeld), .statusOn(statusOn), .learnedN(learnedN),
    .learnedR(learnedR), .setupDone(setupDone), .symValid(symValid),
    .isParity(isParity), .symIdx(symIdx), .blockStart(blockStart),
    .configError(configError)
  );

  int vectors = 0, miscompares = 0;
  bit chkOn = 0, finished = 0;

  // behavioural reference model state
  int ph = -1, lowN = 0, highN = 0, kc = 0, rc = 0, nM = 0, posM = 0, minM = 0;
  int mMode = 0, prevE = 0;
  int eThr = 0, eStat = 0, eN = 0, eR = 0, eDone = 0, eErr = 0;
  int eValid = 0, eStart = 0, ePar = 0, eIdx = 0, eSym = 0;

  always @(posedge clk) begin
    eSym = symIn;
    if (!initN) begin
      if (dataEn) lowN = 0;
      else if (ph == 0) begin if (lowN < 4) lowN++; end
      else lowN = 1;
      ph = 0; highN = 0;
      eThr = thrIn; eStat = statusReq; mMode = latMode;
      kc = 0; rc = 0; eN = 0; eR = 0; eDone = 0; eErr = 0;
      eValid = 0; eStart = 0; ePar = 0; eIdx = 0; posM = 0;
    end else begin
      eValid = 0; eStart = 0;
      case (ph)
        0: begin ph = (lowN >= 4) ? 2 : 1; highN = 1; end
        2: if (highN >= 2 && dataEn && prevE == 0) begin ph = 3; kc = 1; end
           else if (highN < 2) highN++;
        3: if (dataEn) kc++; else begin ph = 4; rc = 1; end
        4: if (!dataEn) rc++;
           else begin
             nM = kc + rc;
             if (mMode >= 2)      minM = (3 * rc) / 2 + 15;
             else if (mMode == 1) minM = 2 * rc + 13;
             else                 minM = 5 * rc + 15;
             eErr = (rc < 8 || rc > 20 || nM > 255 || nM < minM) ? 1 : 0;
             eN = nM; eR = rc; eDone = 1;
             eValid = !eErr; eStart = !eErr; eIdx = 0; ePar = 0;
             posM = 1; ph = 5;
           end
        5: begin
             eValid = !eErr; eStart = (!eErr && posM == 0) ? 1 : 0;
             eIdx = posM; ePar = (posM >= kc) ? 1 : 0;
             posM = (posM == nM - 1) ? 0 : posM + 1;
           end
        default: ;
      endcase
    end
    prevE = dataEn;
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (chkOn && !finished) begin
    cmp("R1 thrHeld", int'(thrHeld), eThr);
    cmp("R1 statusOn", int'(statusOn), eStat);
    cmp("R3 learnedN", int'(learnedN), eN);
    cmp("R3 learnedR", int'(learnedR), eR);
    cmp("R3 setupDone", int'(setupDone), eDone);
    cmp("R8|R9|R10|R12 configError", int'(configError), eErr);
    cmp(eErr ? "R11 symValid" : (eDone ? "R5 symValid" : "R4 symValid"),
        int'(symValid), eValid);
    cmp(eErr ? "R11 blockStart" : "R5 blockStart", int'(blockStart), eStart);
    cmp("R5 symOut", int'(symOut), eSym);
    if (eValid) begin
      cmp("R5 symIdx", int'(symIdx), eIdx);
      cmp("R6 isParity", int'(isParity), ePar);
    end
  end

  task automatic cyc(bit en, int s);
    dataEn = en;
    symIn  = 8'(s);
    @(negedge clk);
  endtask

  // one full setup plus framing run
  task automatic scen(int lowCyc, int p, bit st, int mode, int k, int r, bit wiggle);
    initN = 1'b0; thrIn = 5'(p); statusReq = st; latMode = 2'(mode);
    for (int i = 0; i < lowCyc; i++) cyc(0, i);
    initN = 1'b1;
    thrIn = ~5'(p); statusReq = ~st;     // R1: must not be taken
    latMode = ~2'(mode);                 // R12: must not be taken
    for (int i = 0; i < 3; i++) cyc(0, 3 * i);
    for (int i = 0; i < k; i++) cyc(1, 7 * i + 1);   // training data, R4
    for (int i = 0; i < r; i++) cyc(0, 5 * i + 2);   // training parity
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < k; i++) cyc(wiggle ? 1'($urandom) : 1'b1, 11 * i + b);  // R7
      for (int i = 0; i < r; i++) cyc(wiggle ? 1'($urandom) : 1'b0, 13 * i + b);
    end
    cyc(1, 9);
  endtask

  initial begin
    @(negedge clk);
    chkOn = 1;
    scen(6,  8, 1, 0,  50,  8, 0);  // N58, mode 00 minimum 55: legal
    scen(4, 16, 0, 1,  30, 16, 0);  // mode 01 minimum 45, N46
    scen(5, 20, 1, 3,  25, 20, 0);  // mode 1x, N45 equals minimum (R10)
    scen(4,  9, 0, 2,  19,  9, 0);  // mode 1x, floor(13.5)+15 = 28 = N
    scen(4,  9, 1, 2,  18,  9, 0);  // N27 below 28: R10, R11
    scen(4, 20, 1, 0,  90, 20, 0);  // N110 below 115: R10
    scen(4,  7, 0, 1,  40,  7, 0);  // r below range: R8
    scen(4, 21, 0, 1,  40, 21, 0);  // r above range: R8
    scen(4, 10, 1, 1, 245, 10, 0);  // N255 legal: R9 boundary
    scen(4, 10, 0, 1, 250, 10, 0);  // N260: R9
    scen(3, 12, 1, 1,  40, 12, 0);  // init too short: R2
    scen(5, 12, 0, 1,  40, 12, 1);  // dataEn noise after training: R7
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog all: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule